// File: doc/BRIEF.md
# Embedded Operation Status Word Generator

This block forms the byte a flash device places on its data bus when the host reads while an internal program or erase runs, has failed on timeout, or is suspended. The command parser supplies the operation kind, busy, fail, erase-window and suspend flags, the bit-7 value being programmed, and a mask of sectors selected for erase. The read path supplies the sector of the current read address, the array data for that address, and a read strobe. The block picks either the status byte or the array data and drives a ready level.

Two toggle flags live inside the block. They change once per read, on the falling edge of the read strobe, not on every clock. Several samples taken while one strobe stays high therefore see the same value. One flag moves on any status read of a running or failed operation. The other moves only when the read falls in a sector selected for erase.

The block has no stream interface. Reads are single strobes with no back-pressure. Every pin is a plain level. The status byte and ready are combinational from the inputs and the two flags.

Top module: `flash_opstatus_gen`

## Requirements
- R1: When busy, fail and suspended are all 0, dout equals array_data and ready is 1.
- R2: While busy with op_kind 0 (program) and fail 0, dout bit 7 is the inverse of prog_d7, bit 6 is the main toggle flag, bit 5 is 0, bit 3 is 0, bit 2 is the sector toggle flag, and bits 4, 1 and 0 are 0.
- R3: While busy with op_kind 1 (erase), dout bit 7 is 0. Bit 3 is 0 while erase_win is 1 and becomes 1 once erase_win is 0.
- R4: The main toggle flag (bit 6) inverts exactly once per falling edge of rd_stb while busy or fail is 1. It keeps its value while rd_stb stays high and on reads with busy and fail both 0.
- R5: While fail is 1, dout bit 5 is 1, ready is 0, and both toggle flags keep moving as on a busy read.
- R6: The sector toggle flag (bit 2) inverts on a read falling edge only if erase_mask[rd_sect] is 1 and either an erase is busy or failed, or suspended is 1. Reads of unmasked sectors leave it unchanged.
- R7: With suspended 1 and busy and fail 0, a read of a masked sector returns bit 7 = 1, bit 3 = 1, bit 5 = 0, bit 6 held and bit 2 toggling, with ready 1.
- R8: With suspended 1 and busy and fail 0, a read of an unmasked sector returns array_data and moves neither toggle flag.
- R9: A program that is busy while suspended is 1 reports bit 7 inverted from prog_d7, bit 6 toggling and ready 0.
- R10: Reset clears both toggle flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_kind | input | 1 | Running operation: 0 program, 1 erase |
| busy | input | 1 | Embedded operation in progress |
| fail | input | 1 | Operation exceeded its time limit |
| erase_win | input | 1 | Sector-erase acceptance window still open |
| suspended | input | 1 | An erase is suspended |
| prog_d7 | input | 1 | Bit 7 of the data being programmed |
| erase_mask | input | NUM_SECT | One bit per sector selected for erase |
| rd_sect | input | SW | Sector of the read address |
| rd_stb | input | 1 | Read strobe; toggles advance on its falling edge |
| array_data | input | DW | Array contents at the read address |
| dout | output | DW | Value returned on the data bus |
| ready | output | 1 | High when not busy and not failed |

## Verification
dout and ready are combinational, so they are due in the same cycle as the inputs that set them. The bench drives on the falling clock edge and samples at the next falling edge. A toggle flag changes at the first rising edge where rd_stb is seen low after being seen high. The bench samples each read twice while the strobe is held high, then drops the strobe and waits one rising edge before the next read. A flip can only appear as the new value seen on the following read, and a bench-side model of both flags supplies the expected value.

// File: rtl/flash_opstatus_pkg.sv
package flash_opstatus_pkg;
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;

  // Bit positions decoded by the host's polling routine.
  localparam int B_POLL   = 7;
  localparam int B_TOGALL = 6;
  localparam int B_TMO    = 5;
  localparam int B_STARTD = 3;
  localparam int B_TOGSEC = 2;
endpackage

// File: rtl/flash_opstatus_edge.sv
module flash_opstatus_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic fall
);
  logic stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb;
  end

  assign fall = stb_q & ~stb;
endmodule

// File: rtl/flash_opstatus_flag.sv
module flash_opstatus_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (flip) q <= ~q;
  end
endmodule

// File: rtl/flash_opstatus_mux.sv
module flash_opstatus_mux
  import flash_opstatus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          is_erase,
  input  logic          active,
  input  logic          fail,
  input  logic          erase_win,
  input  logic          susp_hit,
  input  logic          prog_d7,
  input  logic          t_all,
  input  logic          t_sec,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] st;

  always_comb begin
    st = '0;
    if (active) begin
      st[B_POLL]   = is_erase ? 1'b0 : ~prog_d7;
      st[B_TOGALL] = t_all;
      st[B_TMO]    = fail;
      st[B_STARTD] = is_erase & ~erase_win;
      st[B_TOGSEC] = t_sec;
    end else if (susp_hit) begin
      st[B_POLL]   = 1'b1;
      st[B_TOGALL] = t_all;
      st[B_STARTD] = 1'b1;
      st[B_TOGSEC] = t_sec;
    end
  end

  assign dout = (active | susp_hit) ? st : array_data;
endmodule

// File: rtl/flash_opstatus_gen.sv
module flash_opstatus_gen
  import flash_opstatus_pkg::*;
#(
  parameter  int NUM_SECT = 7,
  parameter  int DW       = 8,
  localparam int SW       = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_kind,
  input  logic                busy,
  input  logic                fail,
  input  logic                erase_win,
  input  logic                suspended,
  input  logic                prog_d7,
  input  logic [NUM_SECT-1:0] erase_mask,
  input  logic [SW-1:0]       rd_sect,
  input  logic                rd_stb,
  input  logic [DW-1:0]       array_data,
  output logic [DW-1:0]       dout,
  output logic                ready
);
  logic stb_fall, sect_hit, active, is_erase, susp_hit;
  logic tog6_q, tog2_q, flip6, flip2;

  assign is_erase = (op_kind == OP_ERASE);
  assign active   = busy | fail;
  assign sect_hit = (32'(rd_sect) < NUM_SECT) && erase_mask[rd_sect];
  assign susp_hit = suspended & sect_hit;

  flash_opstatus_edge edge_i (
    .clk(clk), .rst_n(rst_n), .stb(rd_stb), .fall(stb_fall)
  );

  assign flip6 = stb_fall & active;
  assign flip2 = stb_fall & sect_hit & ((active & is_erase) | suspended);

  flash_opstatus_flag tog6_i (.clk(clk), .rst_n(rst_n), .flip(flip6), .q(tog6_q));
  flash_opstatus_flag tog2_i (.clk(clk), .rst_n(rst_n), .flip(flip2), .q(tog2_q));

  flash_opstatus_mux #(.DW(DW)) mux_i (
    .is_erase(is_erase), .active(active), .fail(fail), .erase_win(erase_win),
    .susp_hit(susp_hit), .prog_d7(prog_d7), .t_all(tog6_q), .t_sec(tog2_q),
    .array_data(array_data), .dout(dout)
  );

  assign ready = ~active;
endmodule

// File: rtl/flash_opstatus_chk.sv
module flash_opstatus_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_kind,
  input logic          busy,
  input logic          fail,
  input logic          suspended,
  input logic          prog_d7,
  input logic          sect_hit,
  input logic          stb_fall,
  input logic          tog6_q,
  input logic          tog2_q,
  input logic [DW-1:0] array_data,
  input logic [DW-1:0] dout,
  input logic          ready
);
  a_r1_idle_passes_array: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !fail && !suspended) |-> (dout == array_data && ready));

  a_r2_prog_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fail && !op_kind) |-> (dout[7] == !prog_d7));

  a_r4_flag_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && (busy || fail)) |=> (tog6_q != $past(tog6_q)));

  a_r4_flag_holds_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_fall |=> $stable(tog6_q) && $stable(tog2_q));

  a_r5_busy_level: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || fail) |-> !ready);

  a_r6_unmasked_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && !sect_hit) |=> $stable(tog2_q));

  a_r7_suspend_b6_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && suspended && !busy && !fail) |=> $stable(tog6_q));
endmodule

bind flash_opstatus_gen flash_opstatus_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .busy(busy), .fail(fail),
  .suspended(suspended), .prog_d7(prog_d7), .sect_hit(sect_hit),
  .stb_fall(stb_fall), .tog6_q(tog6_q), .tog2_q(tog2_q),
  .array_data(array_data), .dout(dout), .ready(ready)
);

// File: tb/flash_opstatus_gen_tb_top.sv
`timescale 1ns/1ps
module flash_opstatus_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_kind = 0, busy = 0, fail = 0, erase_win = 0, suspended = 0, prog_d7 = 0;
  logic [6:0] erase_mask = 7'b0010010;   // sectors 1 and 4 selected
  logic [2:0] rd_sect = 0;
  logic       rd_stb = 0;
  logic [7:0] array_data = 0;
  logic [7:0] dout;
  logic       ready;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic mt6 = 0, mt2 = 0;

  always #2 clk = ~clk;

  flash_opstatus_gen dut_i (
    .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .busy(busy), .fail(fail),
    .erase_win(erase_win), .suspended(suspended), .prog_d7(prog_d7),
    .erase_mask(erase_mask), .rd_sect(rd_sect), .rd_stb(rd_stb),
    .array_data(array_data), .dout(dout), .ready(ready)
  );

  typedef struct packed {
    logic b, f, e, w, s, d7;
    logic [2:0] sect;
    logic [7:0] arr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,8'hA5},  // idle
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,3'd1,8'h00},  // program d7=1
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'd2,8'h00},  // program d7=0
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,3'd1,8'h00},  // erase, window open
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,3'd1,8'h00},  // erase started, masked
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,8'h00},  // erase, unmasked read
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,3'd4,8'h00},  // erase timeout
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,3'd3,8'h00},  // program timeout
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,3'd4,8'h3C},  // suspended, masked
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,3'd1,8'h3C},  // suspended, masked
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,3'd2,8'h96},  // suspended, unmasked
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,3'd1,8'h00},  // program during suspend
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd6,8'h5A}   // idle again
  };

  function automatic string tag_of(vec_t v);
    if (v.f)                 return "R5";
    if (v.b && v.s && !v.e)  return "R9";
    if (v.b && !v.e)         return "R2";
    if (v.b)                 return (erase_mask[v.sect] ? "R3/R6" : "R3");
    if (v.s)                 return (erase_mask[v.sect] ? "R7" : "R8");
    return "R1";
  endfunction

  function automatic logic [7:0] model(vec_t v);
    logic [7:0] r = '0;
    logic act = v.b | v.f;
    logic hit = erase_mask[v.sect];
    if (act) begin
      r[7] = v.e ? 1'b0 : ~v.d7;
      r[6] = mt6; r[5] = v.f; r[3] = v.e & ~v.w; r[2] = mt2;
    end else if (v.s && hit) begin
      r[7] = 1'b1; r[6] = mt6; r[3] = 1'b1; r[2] = mt2;
    end else begin
      r = v.arr;
    end
    return r;
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_read(vec_t v);
    logic [7:0] e;
    @(negedge clk);
    busy = v.b; fail = v.f; op_kind = v.e; erase_win = v.w; suspended = v.s;
    prog_d7 = v.d7; rd_sect = v.sect; array_data = v.arr; rd_stb = 1'b1;
    e = model(v);
    @(negedge clk);
    check(tag_of(v), "dout", dout, e);
    check(tag_of(v), "ready", {7'd0, ready}, {7'd0, ~(v.b | v.f)});
    @(negedge clk);
    check("R4", "dout within one strobe", dout, e);
    rd_stb = 1'b0;
    if (v.b | v.f) mt6 = ~mt6;
    if (erase_mask[v.sect] && (((v.b | v.f) && v.e) || v.s)) mt2 = ~mt2;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R10: reset state, busy erase read shows both flags clear
    busy = 1; op_kind = 1; erase_win = 0; rd_sect = 1;
    @(negedge clk);
    check("R10", "flags at reset", dout & 8'h44, 8'h00);
    rst_n = 1;
    busy = 0; op_kind = 0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) do_read(VECS[i]);

    // R4: idle read with a strobe does not move bit 6
    v = '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,8'h11};
    do_read(v);
    v = '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,3'd0,8'h00};
    do_read(v);
    // R8: unmasked suspended reads leave bit 2 alone; masked read shows it
    v = '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,3'd5,8'hC3};
    do_read(v);
    v = '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,3'd4,8'h00};
    do_read(v);
    // R4: strobe held many cycles, no flip until it falls
    @(negedge clk);
    busy = 1; op_kind = 1; fail = 0; suspended = 0; rd_sect = 1; rd_stb = 1;
    repeat (5) @(negedge clk);
    check("R4", "bit6 held over long strobe", {7'd0, dout[6]}, {7'd0, mt6});
    rd_stb = 0; mt6 = ~mt6; mt2 = ~mt2;
    @(negedge clk);
    check("R4", "bit6 after fall", {7'd0, dout[6]}, {7'd0, mt6});
    check("R6", "bit2 after fall", {7'd0, dout[2]}, {7'd0, mt2});
    // R10: reset mid-run clears flags
    if (!mt6) begin
      rd_stb = 1; @(negedge clk); rd_stb = 0; mt6 = ~mt6; mt2 = ~mt2; @(negedge clk);
    end
    rst_n = 0;
    @(negedge clk);
    check("R10", "flags cleared by reset", dout & 8'h44, 8'h00);
    rst_n = 1; mt6 = 0; mt2 = 0;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule